// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block is the digital back end of a column driver for a liquid-crystal panel. A shift-and-sample stage upstream fills a bank of per-channel gray codes. Once per horizontal line a strobe pulse moves that bank into this block. On the rising edge of the strobe the codes and the line's polarity are captured into a holding latch, and the output amplifiers are disconnected. On the falling edge the held codes become the driven codes and the amplifiers are reconnected.

For every channel the block presents the driven code, which half of the gamma reference ladder the channel draws from, and an enable for the switch between the amplifier and the pin. It also presents the two reference taps that bound the code's segment and the 4-bit position inside that segment. Adjacent channels always take opposite ladder halves, and the polarity input exchanges the two halves from line to line. This lets a panel run column, line or dot inversion without moving the common electrode.

The strobe and polarity are synchronous inputs sampled on the block clock. An edge of the strobe is recognised in the clock cycle that first samples its new level.

Top module: `line_latch_steer`

## Requirements
- R1: After synchronous reset every bit of `drv_en` is 0 and every driven code is 0. The enables stay 0 until the first falling edge of the strobe has been recognised.
- R2: At the clock edge that first samples `strobe` high, the whole of `sample_codes` is captured. Later changes of `sample_codes` have no effect on any driven code until the next such edge.
- R3: The driven codes change only at the clock edge that first samples `strobe` low after it was high. At that edge they take the codes captured at the preceding rise, and they hold their previous line throughout the strobe-high interval.
- R4: `drv_en` is all zeros from the clock edge after `strobe` is sampled high. It is all ones from the clock edge that recognises the falling edge, and it stays high until the strobe rises again.
- R5: `polarity` is sampled at the same edge that captures the codes. Changes of `polarity` after that edge have no effect on `drv_half` for that line.
- R6: `drv_half` encodes 0 = upper half (taps 0..4) and 1 = lower half (taps 5..9). Channel index 0 and every even index (the odd-numbered pins) get the line's polarity value. Odd indices get its inverse.
- R7: For a channel in the upper half with code c < 0x3F, `tap_base` = c[5:4], `tap_next` = c[5:4] + 1 and `seg_off` = c[3:0]. Code 0x3F gives `tap_base` = `tap_next` = 4 and `seg_off` = 0.
- R8: For a channel in the lower half, both tap indices are 9 minus the upper-half value for the same code, and `seg_off` is the same as in the upper half. Code 0x00 therefore maps to tap 9 and code 0x3F to tap 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Line transfer pulse, one per horizontal line |
| polarity | input | 1 | Line polarity, captured at strobe rise |
| sample_codes | input | NUM_CH*CODE_W | Codes from the sampling register, channel 0 in the low bits |
| drv_code | output | NUM_CH*CODE_W | Codes currently driven |
| drv_half | output | NUM_CH | Ladder half per channel (0 upper, 1 lower) |
| drv_en | output | NUM_CH | Amplifier-to-pin switch closed per channel |
| seg_off | output | NUM_CH*(CODE_W-SEG_W) | Position inside the tap segment |
| tap_base | output | NUM_CH*TAP_W | Tap at offset zero of the segment |
| tap_next | output | NUM_CH*TAP_W | Far tap of the segment |

## Verification
The bench builds the block with 8 channels and keeps the 6-bit code and 2-bit segment field. Across 32 lines every code from 0x00 to 0x3F then reaches an even-index channel and an odd-index channel under both polarity values. This covers both ladder halves and the 0x3F end point of each half. Each line also scrambles the sample bus and the polarity while the strobe is high, and again after the fall. This exposes any leak past the latch, and the bench checks the enables and the held codes during the high interval.

// File: rtl/lls_pkg.sv
package lls_pkg;

    parameter int unsigned LLS_CHANNELS = 384;
    parameter int unsigned LLS_CODE_W   = 6;
    parameter int unsigned LLS_SEG_W    = 2;

    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_evt_t;

endpackage

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
    import lls_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        polarity,
    output strobe_evt_t evt,
    output logic        drive_pol,
    output logic        out_en
);

    logic stb_q;
    logic line_pol;

    always_comb begin
        evt.rise = strobe & ~stb_q;
        evt.fall = ~strobe & stb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q     <= 1'b0;
            line_pol  <= 1'b0;
            drive_pol <= 1'b0;
            out_en    <= 1'b0;
        end else begin
            stb_q <= strobe;
            if (evt.rise)
                line_pol <= polarity;
            if (evt.fall)
                drive_pol <= line_pol;
            if (strobe)
                out_en <= 1'b0;
            else if (evt.fall)
                out_en <= 1'b1;
        end
    end

    // R4
    en_off_while_high_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !out_en);

    // R4
    en_on_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> out_en);

    // R5
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.rise |=> $stable(line_pol));

    // R5
    drive_pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(drive_pol));

endmodule

// File: rtl/line_store.sv
module line_store
    import lls_pkg::*;
#(
    parameter int unsigned NUM_CH = LLS_CHANNELS,
    parameter int unsigned CODE_W = LLS_CODE_W,
    localparam int unsigned BUS_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_evt_t       evt,
    input  logic [BUS_W-1:0]  sample_codes,
    output logic [BUS_W-1:0]  drive_codes
);

    logic [CODE_W-1:0] hold_q  [NUM_CH];
    logic [CODE_W-1:0] drive_q [NUM_CH];
    logic [BUS_W-1:0]  hold_flat;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[ch]  <= '0;
                drive_q[ch] <= '0;
            end else begin
                if (evt.rise)
                    hold_q[ch] <= sample_codes[ch*CODE_W +: CODE_W];
                if (evt.fall)
                    drive_q[ch] <= hold_q[ch];
            end
        end
        assign hold_flat[ch*CODE_W +: CODE_W]   = hold_q[ch];
        assign drive_codes[ch*CODE_W +: CODE_W] = drive_q[ch];
    end

    // R2
    capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> (hold_flat == $past(sample_codes)));

    // R2
    hold_between_rises_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.rise |=> $stable(hold_flat));

    // R3
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(drive_codes));

    // R3
    drive_load_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> (drive_codes == $past(hold_flat)));

endmodule

// File: rtl/tap_mapper.sv
module tap_mapper
    import lls_pkg::*;
#(
    parameter int unsigned CODE_W = LLS_CODE_W,
    parameter int unsigned SEG_W  = LLS_SEG_W,
    localparam int unsigned OFF_W = CODE_W - SEG_W,
    localparam int unsigned SEGS  = 1 << SEG_W,
    localparam int unsigned TOP   = 2 * SEGS + 1,
    localparam int unsigned TAP_W = $clog2(TOP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  half_e             half,
    output logic [OFF_W-1:0]  off,
    output logic [TAP_W-1:0]  base,
    output logic [TAP_W-1:0]  next
);

    logic             at_end;
    logic [TAP_W-1:0] up_base;
    logic [TAP_W-1:0] up_next;

    always_comb begin
        at_end  = &code;
        up_base = at_end ? TAP_W'(SEGS) : TAP_W'(code[CODE_W-1:OFF_W]);
        up_next = at_end ? TAP_W'(SEGS) : up_base + TAP_W'(1);
        off     = at_end ? '0 : code[OFF_W-1:0];
        if (half == HALF_LOWER) begin
            base = TAP_W'(TOP) - up_base;
            next = TAP_W'(TOP) - up_next;
        end else begin
            base = up_base;
            next = up_next;
        end
    end

    // R7
    upper_range_chk: assert property (@(posedge clk) disable iff (rst)
        (half == HALF_UPPER) |-> (base <= TAP_W'(SEGS) && next <= TAP_W'(SEGS)));

    // R8
    lower_range_chk: assert property (@(posedge clk) disable iff (rst)
        (half == HALF_LOWER) |-> (base > TAP_W'(SEGS) && next > TAP_W'(SEGS)));

    // R7
    end_point_chk: assert property (@(posedge clk) disable iff (rst)
        (base == next) |-> (off == '0));

endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer
    import lls_pkg::*;
#(
    parameter int unsigned NUM_CH = LLS_CHANNELS,
    parameter int unsigned CODE_W = LLS_CODE_W,
    parameter int unsigned SEG_W  = LLS_SEG_W,
    localparam int unsigned OFF_W = CODE_W - SEG_W,
    localparam int unsigned TOP   = 2 * (1 << SEG_W) + 1,
    localparam int unsigned TAP_W = $clog2(TOP + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strobe,
    input  logic                      polarity,
    input  logic [NUM_CH*CODE_W-1:0]  sample_codes,
    output logic [NUM_CH*CODE_W-1:0]  drv_code,
    output logic [NUM_CH-1:0]         drv_half,
    output logic [NUM_CH-1:0]         drv_en,
    output logic [NUM_CH*OFF_W-1:0]   seg_off,
    output logic [NUM_CH*TAP_W-1:0]   tap_base,
    output logic [NUM_CH*TAP_W-1:0]   tap_next
);

    strobe_evt_t evt;
    logic        drive_pol;
    logic        out_en;

    strobe_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .polarity  (polarity),
        .evt       (evt),
        .drive_pol (drive_pol),
        .out_en    (out_en)
    );

    line_store #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .sample_codes (sample_codes),
        .drive_codes  (drv_code)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic ODD_IDX = logic'(ch % 2);
        half_e ch_half;

        assign ch_half      = half_e'(drive_pol ^ ODD_IDX);
        assign drv_half[ch] = ch_half;
        assign drv_en[ch]   = out_en;

        tap_mapper #(
            .CODE_W (CODE_W),
            .SEG_W  (SEG_W)
        ) u_map (
            .clk  (clk),
            .rst  (rst),
            .code (drv_code[ch*CODE_W +: CODE_W]),
            .half (ch_half),
            .off  (seg_off[ch*OFF_W +: OFF_W]),
            .base (tap_base[ch*TAP_W +: TAP_W]),
            .next (tap_next[ch*TAP_W +: TAP_W])
        );
    end

    if (NUM_CH > 1) begin : g_pair_chk
        // R6
        neighbour_halves_chk: assert property (@(posedge clk) disable iff (rst)
            drv_half[0] != drv_half[1]);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (drv_en == '0 && drv_code == '0));

endmodule

// File: tb/line_latch_steer_bench.sv
module line_latch_steer_bench;

    localparam int NCH  = 8;
    localparam int CW   = 6;
    localparam int SW   = 2;
    localparam int OW   = CW - SW;
    localparam int TW   = 4;
    localparam int MAXC = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strobe = 1'b0;
    logic              polarity = 1'b0;
    logic [NCH*CW-1:0] sample_codes = '0;
    logic [NCH*CW-1:0] drv_code;
    logic [NCH-1:0]    drv_half;
    logic [NCH-1:0]    drv_en;
    logic [NCH*OW-1:0] seg_off;
    logic [NCH*TW-1:0] tap_base;
    logic [NCH*TW-1:0] tap_next;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    line_latch_steer #(.NUM_CH(NCH), .CODE_W(CW), .SEG_W(SW)) u_line_latch_steer (
        .clk (clk), .rst (rst), .strobe (strobe), .polarity (polarity),
        .sample_codes (sample_codes), .drv_code (drv_code), .drv_half (drv_half),
        .drv_en (drv_en), .seg_off (seg_off), .tap_base (tap_base), .tap_next (tap_next)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int code_at(input int line, input int ch);
        return (line / 4) * 8 + ((ch + (line / 2) % 2) % 8);
    endfunction

    task automatic check_line(input int line, input int pol);
        for (int ch = 0; ch < NCH; ch++) begin
            int c    = code_at(line, ch);
            int half = pol ^ (ch % 2);
            int b    = (c == 63) ? 4 : c / 16;
            int n    = (c == 63) ? 4 : c / 16 + 1;
            int o    = (c == 63) ? 0 : c % 16;
            if (half == 1) begin
                b = 9 - b;
                n = 9 - n;
            end
            chk("R3 code", int'(drv_code[ch*CW +: CW]), c);
            chk("R6 half", int'(drv_half[ch]), half);
            chk("R4 enable", int'(drv_en[ch]), 1);
            chk(half ? "R8 offset" : "R7 offset", int'(seg_off[ch*OW +: OW]), o);
            chk(half ? "R8 base" : "R7 base", int'(tap_base[ch*TW +: TW]), b);
            chk(half ? "R8 next" : "R7 next", int'(tap_next[ch*TW +: TW]), n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 enables", int'(drv_en), 0);
        chk("R1 codes", int'(drv_code != '0), 0);

        for (int line = 0; line < 32; line++) begin
            int pol = line % 2;
            for (int ch = 0; ch < NCH; ch++)
                sample_codes[ch*CW +: CW] = CW'(code_at(line, ch));
            polarity = pol[0];
            strobe   = 1'b1;
            @(negedge clk);
            // R2: scramble after the rise edge; R5: flip polarity
            sample_codes = ~sample_codes;
            polarity     = ~pol[0];
            @(negedge clk);
            chk("R4 off while high", int'(drv_en), 0);
            if (line > 0)
                chk("R3 hold while high", int'(drv_code[CW-1:0]), code_at(line - 1, 0));
            else
                chk("R1 still zero", int'(drv_code[CW-1:0]), 0);
            @(negedge clk);
            strobe = 1'b0;
            @(negedge clk);
            sample_codes = '1;
            polarity     = ~polarity;
            @(negedge clk);
            // R2 R5 R3 R6 R7 R8 after the fall
            check_line(line, pol);
            @(negedge clk);
            chk("R4 stays on", int'(drv_en), (1 << NCH) - 1);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (MAXC) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule